// File: doc/BRIEF.md
# Display Refresh Fetch DMA with Split Line FIFOs

This block keeps a display pipeline supplied with pixel words without software help. It reads frame memory in fixed bursts of four 32-bit words through a request/grant bus port. It keeps the bus locked for the whole burst and places each returned word into one of two local FIFOs of different depths. A downstream video formatter drains those FIFOs one word per read strobe.

The block has two modes. In single-scan mode the upper FIFO (16 words) receives every burst and the lower FIFO (12 words) stays idle. In dual-scan mode each half of the panel has its own FIFO, its own fetch address and its own programmed base address. The two halves take turns on the bus when both need data. Each half counts its bursts and returns to its base address once a programmed number of bursts per frame has been fetched. Deasserting the enable input empties both FIFOs, returns both address counters to their bases and abandons any pending request.

Top module: `lcd_fetch_dma`

## Requirements
- R1: A fetch raises `bus_req` with `bus_addr` set to the current address of the target half, aligned down to 16 bytes. `bus_req` and `bus_addr` hold steady until the cycle in which `bus_gnt` is seen. The four following cycles with `bus_rvalid` high each deliver one word.
- R2: `bus_lock` is high from the first request cycle through the cycle of the fourth data beat. It is low one cycle later, and low whenever no fetch is in progress.
- R3: A fetch is started for a FIFO only when that FIFO has at least 4 free entries, so a FIFO never holds more words than its depth.
- R4: A FIFO that has been partly drained, to 4 or more free entries, triggers a new fetch without having to become empty first.
- R5: With `dual_scan` = 0, every fetch targets the upper half: `up_base`, the upper FIFO and its counters. The lower FIFO stays empty.
- R6: With `dual_scan` = 1, both halves are fetched. When both FIFOs have room, fetches alternate between them. The first fetch after enable goes to the lower half.
- R7: Each half's fetch address starts at its aligned base and advances by 16 after each completed burst for that half. After `frame_bursts` bursts it reloads its base. A value of 0 is treated as 1.
- R8: Each FIFO presents its oldest word on its data output (show-ahead). A read strobe on a non-empty FIFO removes exactly one word, and words leave in the order they arrived.
- R9: A read strobe on an empty FIFO is ignored and raises that FIFO's underrun output for exactly the following cycle.
- R10: While `enable` is 0, both FIFOs read as empty, `bus_req` and `bus_lock` are low, and the next enabled fetch of each half starts at its base address.
- R11: After reset, `bus_req`, `bus_lock` and both underrun outputs are 0, and both empty outputs are 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Fetch enable; low clears FIFOs and address counters |
| dual_scan | input | 1 | 1 = two panel halves, 0 = upper half only |
| up_base | input | 32 | Frame base byte address of the upper half |
| lo_base | input | 32 | Frame base byte address of the lower half |
| frame_bursts | input | 16 | Bursts per frame for each half |
| bus_req | output | 1 | Burst read request |
| bus_lock | output | 1 | Bus held for the current burst |
| bus_addr | output | 32 | Burst start byte address |
| bus_gnt | input | 1 | Arbiter grant for the pending request |
| bus_rvalid | input | 1 | Read data beat valid |
| bus_rdata | input | 32 | Read data beat |
| up_rd | input | 1 | Upper FIFO read strobe |
| up_rdata | output | 32 | Upper FIFO head word |
| up_empty | output | 1 | Upper FIFO empty |
| up_underrun | output | 1 | Upper FIFO read while empty (one-cycle pulse) |
| lo_rd | input | 1 | Lower FIFO read strobe |
| lo_rdata | output | 32 | Lower FIFO head word |
| lo_empty | output | 1 | Lower FIFO empty |
| lo_underrun | output | 1 | Lower FIFO read while empty (one-cycle pulse) |

## Verification
The bound checker watches the bus handshake on every cycle: the request stays stable until grant, the lock covers exactly four beats, and addresses are aligned. It also checks that neither FIFO level exceeds its depth, that the lower FIFO stays empty in single-scan mode, that an empty read produces the underrun pulse, and that a disable clears everything. Other properties need whole sequences to show and are covered only by the directed scenarios. These are the order in which halves are chosen, the address wrap at frame end, the refill after a partial drain, and whether the words leave each FIFO in arrival order.

// File: rtl/lfd_pkg.sv
package lfd_pkg;
    localparam int BURST_LEN   = 4;
    localparam int WORD_BYTES  = 4;
    localparam int BURST_BYTES = BURST_LEN * WORD_BYTES;
    localparam int BURST_OFF   = $clog2(BURST_BYTES);
    localparam int BEAT_W      = $clog2(BURST_LEN);
    localparam int NUM_HALVES  = 2;
    localparam int HALF_UP     = 0;
    localparam int HALF_LO     = 1;

    typedef enum logic [1:0] {
        CTL_IDLE = 2'd0,
        CTL_REQ  = 2'd1,
        CTL_DATA = 2'd2
    } ctl_state_e;

    typedef struct packed {
        ctl_state_e        state;
        logic              tgt;
        logic [BEAT_W-1:0] beat;
        logic              turn_lo;
    } ctl_reg_t;
endpackage

// File: rtl/lfd_fifo.sv
module lfd_fifo
    import lfd_pkg::*;
#(
    parameter int DW    = 32,
    parameter int DEPTH = 16,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    output logic          empty,
    output logic          room,
    output logic          underrun,
    output logic [LW-1:0] level
);
    typedef struct packed {
        logic [PW-1:0] wp;
        logic [PW-1:0] rp;
        logic [LW-1:0] lvl;
        logic          unf;
    } fifo_reg_t;

    fifo_reg_t     st_d, st_q;
    logic [DW-1:0] mem_d [DEPTH];
    logic [DW-1:0] mem_q [DEPTH];
    logic          do_wr, do_rd;

    function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_comb begin
        st_d  = st_q;
        mem_d = mem_q;
        do_wr = wr_en && (st_q.lvl < LW'(DEPTH));
        do_rd = rd_en && (st_q.lvl != '0);
        if (do_wr) begin
            mem_d[st_q.wp] = wr_data;
            st_d.wp        = ptr_next(st_q.wp);
        end
        if (do_rd) begin
            st_d.rp = ptr_next(st_q.rp);
        end
        st_d.lvl = st_q.lvl + LW'(do_wr) - LW'(do_rd);
        st_d.unf = rd_en && (st_q.lvl == '0);
        if (clr) begin
            st_d.wp  = '0;
            st_d.rp  = '0;
            st_d.lvl = '0;
            st_d.unf = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        mem_q <= mem_d;
    end

    assign rd_data  = mem_q[st_q.rp];
    assign empty    = (st_q.lvl == '0);
    assign room     = (LW'(DEPTH) - st_q.lvl) >= LW'(BURST_LEN);
    assign underrun = st_q.unf;
    assign level    = st_q.lvl;
endmodule

// File: rtl/lfd_addr_gen.sv
module lfd_addr_gen
    import lfd_pkg::*;
#(
    parameter int AW    = 32,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [AW-1:0]    base,
    input  logic [CNT_W-1:0] frame_bursts,
    input  logic             advance,
    output logic [AW-1:0]    addr
);
    typedef struct packed {
        logic [AW-1:0]    addr;
        logic [CNT_W-1:0] cnt;
        logic             loaded;
    } agen_reg_t;

    agen_reg_t        st_d, st_q;
    logic [AW-1:0]    base_al;
    logic [AW-1:0]    cur;
    logic             last;

    assign base_al = {base[AW-1:BURST_OFF], {BURST_OFF{1'b0}}};
    assign cur     = st_q.loaded ? st_q.addr : base_al;
    assign last    = ({1'b0, st_q.cnt} + (CNT_W+1)'(1)) >= {1'b0, frame_bursts};

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.addr   = base_al;
            st_d.cnt    = '0;
            st_d.loaded = 1'b0;
        end else if (advance) begin
            st_d.loaded = 1'b1;
            if (last) begin
                st_d.addr = base_al;
                st_d.cnt  = '0;
            end else begin
                st_d.addr = cur + AW'(BURST_BYTES);
                st_d.cnt  = st_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign addr = cur;
endmodule

// File: rtl/lfd_burst_ctl.sv
module lfd_burst_ctl
    import lfd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic dual_scan,
    input  logic up_room,
    input  logic lo_room,
    input  logic bus_gnt,
    input  logic bus_rvalid,
    output logic bus_req,
    output logic bus_lock,
    output logic tgt,
    output logic wr_beat,
    output logic burst_done
);
    localparam ctl_reg_t CTL_RST = '{state: CTL_IDLE, tgt: 1'b0, beat: '0, turn_lo: 1'b1};

    ctl_reg_t st_d, st_q;
    logic     want_lo, want_up;

    always_comb begin
        st_d       = st_q;
        wr_beat    = 1'b0;
        burst_done = 1'b0;
        want_lo    = dual_scan && lo_room;
        want_up    = up_room;
        case (st_q.state)
            CTL_IDLE: begin
                if (want_lo && (!want_up || st_q.turn_lo)) begin
                    st_d.tgt   = 1'(HALF_LO);
                    st_d.state = CTL_REQ;
                end else if (want_up) begin
                    st_d.tgt   = 1'(HALF_UP);
                    st_d.state = CTL_REQ;
                end
            end
            CTL_REQ: begin
                if (bus_gnt) begin
                    st_d.state = CTL_DATA;
                    st_d.beat  = '0;
                end
            end
            CTL_DATA: begin
                if (bus_rvalid) begin
                    wr_beat = 1'b1;
                    if (st_q.beat == BEAT_W'(BURST_LEN - 1)) begin
                        burst_done   = 1'b1;
                        st_d.state   = CTL_IDLE;
                        st_d.turn_lo = (st_q.tgt == 1'(HALF_UP));
                    end else begin
                        st_d.beat = st_q.beat + BEAT_W'(1);
                    end
                end
            end
            default: st_d = CTL_RST;
        endcase
        if (!enable) begin
            st_d       = CTL_RST;
            wr_beat    = 1'b0;
            burst_done = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= CTL_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_req  = (st_q.state == CTL_REQ);
    assign bus_lock = (st_q.state != CTL_IDLE);
    assign tgt      = st_q.tgt;
endmodule

// File: rtl/lcd_fetch_dma.sv
module lcd_fetch_dma
    import lfd_pkg::*;
#(
    parameter int AW       = 32,
    parameter int DW       = 32,
    parameter int UP_DEPTH = 16,
    parameter int LO_DEPTH = 12,
    parameter int CNT_W    = 16,
    localparam int MAX_DEPTH = (UP_DEPTH > LO_DEPTH) ? UP_DEPTH : LO_DEPTH,
    localparam int LVL_W     = $clog2(MAX_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             dual_scan,
    input  logic [AW-1:0]    up_base,
    input  logic [AW-1:0]    lo_base,
    input  logic [CNT_W-1:0] frame_bursts,
    output logic             bus_req,
    output logic             bus_lock,
    output logic [AW-1:0]    bus_addr,
    input  logic             bus_gnt,
    input  logic             bus_rvalid,
    input  logic [DW-1:0]    bus_rdata,
    input  logic             up_rd,
    output logic [DW-1:0]    up_rdata,
    output logic             up_empty,
    output logic             up_underrun,
    input  logic             lo_rd,
    output logic [DW-1:0]    lo_rdata,
    output logic             lo_empty,
    output logic             lo_underrun
);
    logic             tgt, wr_beat, burst_done, clr;
    logic             rd_a    [NUM_HALVES];
    logic [DW-1:0]    rdata_a [NUM_HALVES];
    logic             empty_a [NUM_HALVES];
    logic             room_a  [NUM_HALVES];
    logic             unf_a   [NUM_HALVES];
    logic [LVL_W-1:0] lvl_a   [NUM_HALVES];
    logic [AW-1:0]    base_a  [NUM_HALVES];
    logic [AW-1:0]    addr_a  [NUM_HALVES];

    assign clr             = !enable;
    assign rd_a[HALF_UP]   = up_rd;
    assign rd_a[HALF_LO]   = lo_rd;
    assign base_a[HALF_UP] = up_base;
    assign base_a[HALF_LO] = lo_base;

    lfd_burst_ctl u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .dual_scan  (dual_scan),
        .up_room    (room_a[HALF_UP]),
        .lo_room    (room_a[HALF_LO]),
        .bus_gnt    (bus_gnt),
        .bus_rvalid (bus_rvalid),
        .bus_req    (bus_req),
        .bus_lock   (bus_lock),
        .tgt        (tgt),
        .wr_beat    (wr_beat),
        .burst_done (burst_done)
    );

    for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
        localparam int DEPTH = (h == HALF_UP) ? UP_DEPTH : LO_DEPTH;
        localparam int LW    = $clog2(DEPTH + 1);
        logic [LW-1:0] lvl;
        logic          sel;

        assign sel      = (tgt == 1'(h));
        assign lvl_a[h] = LVL_W'(lvl);

        lfd_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr      (clr),
            .wr_en    (wr_beat && sel),
            .wr_data  (bus_rdata),
            .rd_en    (rd_a[h]),
            .rd_data  (rdata_a[h]),
            .empty    (empty_a[h]),
            .room     (room_a[h]),
            .underrun (unf_a[h]),
            .level    (lvl)
        );

        lfd_addr_gen #(.AW(AW), .CNT_W(CNT_W)) u_agen (
            .clk          (clk),
            .rst_n        (rst_n),
            .clr          (clr),
            .base         (base_a[h]),
            .frame_bursts (frame_bursts),
            .advance      (burst_done && sel),
            .addr         (addr_a[h])
        );
    end

    assign bus_addr    = addr_a[tgt];
    assign up_rdata    = rdata_a[HALF_UP];
    assign up_empty    = empty_a[HALF_UP];
    assign up_underrun = unf_a[HALF_UP];
    assign lo_rdata    = rdata_a[HALF_LO];
    assign lo_empty    = empty_a[HALF_LO];
    assign lo_underrun = unf_a[HALF_LO];
endmodule

// File: rtl/lfd_checker.sv
module lfd_checker #(
    parameter int AW       = 32,
    parameter int UP_DEPTH = 16,
    parameter int LO_DEPTH = 12,
    parameter int LVL_W    = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable,
    input logic             dual_scan,
    input logic             bus_req,
    input logic             bus_lock,
    input logic [AW-1:0]    bus_addr,
    input logic             bus_gnt,
    input logic             bus_rvalid,
    input logic             up_rd,
    input logic             up_empty,
    input logic             up_underrun,
    input logic             lo_rd,
    input logic             lo_empty,
    input logic             lo_underrun,
    input logic [LVL_W-1:0] up_level,
    input logic [LVL_W-1:0] lo_level
);
    logic [2:0] beat_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            beat_q <= '0;
        end else if (!enable || !bus_lock) begin
            beat_q <= '0;
        end else if (bus_rvalid && !bus_req) begin
            beat_q <= beat_q + 3'd1;
        end
    end

    p_req_hold_r1: assert property (@(posedge clk) disable iff (!rst_n || !enable)
        bus_req && !bus_gnt |=> enable -> (bus_req && $stable(bus_addr)));

    p_addr_align_r1: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> bus_addr[3:0] == 4'd0);

    p_req_locked_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> bus_lock);

    p_lock_beats_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_lock) && enable && $past(enable) |-> beat_q == 3'd4);

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        up_level <= LVL_W'(UP_DEPTH) && lo_level <= LVL_W'(LO_DEPTH));

    p_single_lo_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        enable && !dual_scan && $past(enable && !dual_scan) && $past(lo_level) == '0
        |-> lo_level == '0);

    p_up_underrun_r9: assert property (@(posedge clk) disable iff (!rst_n || !enable)
        up_rd && up_empty |=> up_underrun);

    p_lo_underrun_r9: assert property (@(posedge clk) disable iff (!rst_n || !enable)
        lo_rd && lo_empty |=> lo_underrun);

    p_disable_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> up_empty && lo_empty && !bus_req);
endmodule

bind lcd_fetch_dma lfd_checker #(
    .AW(AW), .UP_DEPTH(UP_DEPTH), .LO_DEPTH(LO_DEPTH), .LVL_W(LVL_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .dual_scan   (dual_scan),
    .bus_req     (bus_req),
    .bus_lock    (bus_lock),
    .bus_addr    (bus_addr),
    .bus_gnt     (bus_gnt),
    .bus_rvalid  (bus_rvalid),
    .up_rd       (up_rd),
    .up_empty    (up_empty),
    .up_underrun (up_underrun),
    .lo_rd       (lo_rd),
    .lo_empty    (lo_empty),
    .lo_underrun (lo_underrun),
    .up_level    (lvl_a[0]),
    .lo_level    (lvl_a[1])
);

// File: tb/lcd_fetch_dma_tb.sv
`timescale 1ns/1ps
module lcd_fetch_dma_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        dual_scan = 1'b0;
    logic [31:0] up_base = '0;
    logic [31:0] lo_base = '0;
    logic [15:0] frame_bursts = 16'd1;
    logic        bus_req, bus_lock;
    logic [31:0] bus_addr;
    logic        bus_gnt = 1'b0;
    logic        bus_rvalid = 1'b0;
    logic [31:0] bus_rdata = '0;
    logic        up_rd = 1'b0, lo_rd = 1'b0;
    logic [31:0] up_rdata, lo_rdata;
    logic        up_empty, up_underrun, lo_empty, lo_underrun;

    int          n_chk = 0;
    int          n_bad = 0;
    bit          finished = 1'b0;
    logic [31:0] q_up [$];
    logic [31:0] q_lo [$];

    always #2.5 clk = ~clk;

    lcd_fetch_dma u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .dual_scan(dual_scan),
        .up_base(up_base), .lo_base(lo_base), .frame_bursts(frame_bursts),
        .bus_req(bus_req), .bus_lock(bus_lock), .bus_addr(bus_addr),
        .bus_gnt(bus_gnt), .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata),
        .up_rd(up_rd), .up_rdata(up_rdata), .up_empty(up_empty), .up_underrun(up_underrun),
        .lo_rd(lo_rd), .lo_rdata(lo_rdata), .lo_empty(lo_empty), .lo_underrun(lo_underrun)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    // Grant one burst, return 4 words whose value is their byte address.
    task automatic serve_burst(input string req, input logic [31:0] exp_addr, input bit to_lo);
        int waited = 0;
        while (!bus_req && waited < 40) begin
            @(negedge clk);
            waited++;
        end
        chk({req, " request raised"}, 32'(bus_req), 32'd1);
        chk({req, " burst address"}, bus_addr, exp_addr);
        bus_gnt = 1'b1;
        @(negedge clk);
        bus_gnt = 1'b0;
        for (int i = 0; i < 4; i++) begin
            chk("R2 lock during beat", 32'(bus_lock), 32'd1);
            bus_rvalid = 1'b1;
            bus_rdata  = bus_addr + 32'(4 * i);
            if (to_lo) q_lo.push_back(bus_rdata);
            else       q_up.push_back(bus_rdata);
            @(negedge clk);
        end
        bus_rvalid = 1'b0;
        chk("R2 lock released after fourth beat", 32'(bus_lock), 32'd0);
    endtask

    task automatic read_word(input string req, input bit from_lo);
        logic [31:0] exp;
        exp = from_lo ? q_lo.pop_front() : q_up.pop_front();
        chk({req, " not empty"}, 32'(from_lo ? lo_empty : up_empty), 32'd0);
        chk({req, " head word"}, from_lo ? lo_rdata : up_rdata, exp);
        if (from_lo) lo_rd = 1'b1; else up_rd = 1'b1;
        @(negedge clk);
        lo_rd = 1'b0;
        up_rd = 1'b0;
    endtask

    task automatic no_request(input string req, input int cycles);
        logic seen = 1'b0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            seen |= bus_req;
        end
        chk(req, 32'(seen), 32'd0);
    endtask

    task automatic pulse_disable();
        enable = 1'b0;
        q_up.delete();
        q_lo.delete();
        @(negedge clk);
        @(negedge clk);
        chk("R10 upper empty while disabled", 32'(up_empty), 32'd1);
        chk("R10 lower empty while disabled", 32'(lo_empty), 32'd1);
        chk("R10 no request while disabled", 32'(bus_req), 32'd0);
        chk("R10 no lock while disabled", 32'(bus_lock), 32'd0);
    endtask

    task automatic t_reset();
        chk("R11 bus_req", 32'(bus_req), 32'd0);
        chk("R11 bus_lock", 32'(bus_lock), 32'd0);
        chk("R11 up_empty", 32'(up_empty), 32'd1);
        chk("R11 lo_empty", 32'(lo_empty), 32'd1);
        chk("R11 underruns", {30'd0, up_underrun, lo_underrun}, 32'd0);
    endtask

    task automatic t_single_scan();
        dual_scan    = 1'b0;
        up_base      = 32'h0000_1000;
        lo_base      = 32'h0000_9000;
        frame_bursts = 16'd3;
        enable       = 1'b1;
        // R7: three bursts per frame, then back to base
        serve_burst("R7 single", 32'h1000, 1'b0);
        serve_burst("R7 single", 32'h1010, 1'b0);
        serve_burst("R7 single", 32'h1020, 1'b0);
        serve_burst("R7 wrap to base", 32'h1000, 1'b0);
        no_request("R3 no request when upper full", 10);
        chk("R5 lower untouched in single scan", 32'(lo_empty), 32'd1);
        read_word("R8 upper", 1'b0);
        no_request("R3 no request with only one free entry", 8);
        for (int i = 0; i < 3; i++) read_word("R8 upper", 1'b0);
        serve_burst("R4 refill after partial drain", 32'h1010, 1'b0);
        while (q_up.size() > 0) read_word("R8 upper order", 1'b0);
        chk("R8 upper drained", 32'(up_empty), 32'd1);
        chk("R5 lower still empty", 32'(lo_empty), 32'd1);
    endtask

    task automatic t_underrun();
        chk("R9 upper empty before read", 32'(up_empty), 32'd1);
        up_rd = 1'b1;
        lo_rd = 1'b1;
        @(negedge clk);
        up_rd = 1'b0;
        lo_rd = 1'b0;
        chk("R9 upper underrun pulse", 32'(up_underrun), 32'd1);
        chk("R9 lower underrun pulse", 32'(lo_underrun), 32'd1);
        chk("R9 upper stays empty", 32'(up_empty), 32'd1);
        @(negedge clk);
        chk("R9 underrun lasts one cycle", {30'd0, up_underrun, lo_underrun}, 32'd0);
    endtask

    task automatic t_disable();
        pulse_disable();
        up_base = 32'h0000_2008; // unaligned: expect 0x2000
        enable  = 1'b1;
        serve_burst("R10 restart at base (R1 aligned)", 32'h2000, 1'b0);
        serve_burst("R7 advance by 16", 32'h2010, 1'b0);
        // leave a request pending, then drop enable
        @(negedge clk);
        pulse_disable();
        enable = 1'b1;
        serve_burst("R10 counters cleared", 32'h2000, 1'b0);
        read_word("R10 only new data", 1'b0);
    endtask

    task automatic t_dual_scan();
        pulse_disable();
        dual_scan    = 1'b1;
        up_base      = 32'h0000_4000;
        lo_base      = 32'h0000_8000;
        frame_bursts = 16'd2;
        enable       = 1'b1;
        serve_burst("R6 lower first", 32'h8000, 1'b1);
        serve_burst("R6 alternate to upper", 32'h4000, 1'b0);
        serve_burst("R6 alternate to lower", 32'h8010, 1'b1);
        serve_burst("R6 alternate to upper", 32'h4010, 1'b0);
        serve_burst("R7 lower wraps", 32'h8000, 1'b1);
        serve_burst("R7 upper wraps", 32'h4000, 1'b0);
        serve_burst("R3 lower full, upper only", 32'h4010, 1'b0);
        no_request("R3 both full, no request", 10);
        while (q_lo.size() > 0) read_word("R6 lower stream", 1'b1);
        chk("R6 lower drained", 32'(lo_empty), 32'd1);
        for (int i = 0; i < 4; i++) read_word("R6 upper stream", 1'b0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_single_scan();
        t_underrun();
        t_disable();
        t_dual_scan();
        @(negedge clk);
        finish_run();
    end
endmodule